// File: doc/BRIEF.md
# Flit-to-Phit Link Serializer

This block moves fixed 70-bit flits across a 14-bit link. A flit is 64 data bits with 6 control bits above them, and two of the control bits give the flit's kind. On the sending side a flit is offered through a valid/ready handshake and leaves as five consecutive phits. When nothing is offered at a flit boundary, the sender fills the slot with an idle flit, so the link never falls silent. On the receiving side five phits are packed back into a flit. Idle flits are dropped there, and packet boundaries are marked at the output.

Both ends share one clock. The link is a chain of registers with a parameter for its depth. The receiver also checks packet length. A packet is a routing-tag flit followed by its data flits, and the last data flit has the end-of-packet kind. Only 1-word and 8-word requests are legal. The transmit output is brought out as the link pins so that the phit stream can be observed.

Top module: `flit_phit_link`

## Requirements
- R1: A flit holds data in bits [63:0] and control in bits [69:64]. Flit bits [65:64] give the kind: 0 is idle (no information), 1 is routing tag, 2 is packet body and 3 is end-of-packet. Bits [69:66] are carried through unchanged.
- R2: Each flit is sent as exactly five 14-bit phits on consecutive cycles. Phit i carries flit bits [14i+13:14i], starting with i=0. From the first clock edge after reset, link_phit_vld is high on every cycle.
- R3: tx_ready is high in exactly one cycle of every five. A flit is taken when tx_valid and tx_ready are both high at a clock edge. After that, tx_ready stays low for the four cycles in which phits 1 to 4 are sent.
- R4: When no flit is taken at a flit boundary, an all-zero idle flit goes out, so link_phit reads zero for those five cycles.
- R5: Every non-idle flit taken by the sender appears once on rx_flit with a one-cycle rx_flit_vld pulse. It is bit-exact and arrives in the order sent.
- R6: Idle flits never raise rx_flit_vld. This holds whether the sender inserts them or the user offers them.
- R7: rx_eop is high together with rx_flit_vld exactly when the delivered flit's kind is end-of-packet.
- R8: rx_frame_err is high together with an end-of-packet delivery when the packet's data-flit count is neither 1 nor 8. The count is the body flits since the last routing tag or end-of-packet, plus the end-of-packet flit itself.
- R9: While rst_n is low, link_phit_vld, rx_flit_vld, rx_eop and rx_frame_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both link ends |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_flit | input | 70 | Flit offered for sending |
| tx_valid | input | 1 | tx_flit is valid |
| tx_ready | output | 1 | Sender can take a flit at this edge |
| link_phit | output | 14 | Phit being driven onto the link |
| link_phit_vld | output | 1 | Phit strobe |
| rx_flit | output | 70 | Rebuilt flit |
| rx_flit_vld | output | 1 | One-cycle pulse for each delivered non-idle flit |
| rx_eop | output | 1 | Delivered flit is end-of-packet |
| rx_frame_err | output | 1 | End-of-packet closed a packet of illegal length |

## Verification
A framing verdict and a flit delivery fall in the same cycle, because the length check is made on the very end-of-packet flit being handed out. Flits are offered back to back, so new flits are accepted on the transmit side while earlier ones are still being delivered. Packets of 1, 2, 8 and 9 data flits are sent, along with a tag that cuts a packet short. The scoreboard then compares the error and end flags together with the flit contents on each delivery pulse.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;
  localparam int FLIT_DATA_W = 64;
  localparam int FLIT_CTRL_W = 6;
  localparam int FLIT_W      = FLIT_DATA_W + FLIT_CTRL_W;
  localparam int PHIT_W      = 14;
  localparam int N_PHITS     = (FLIT_W + PHIT_W - 1) / PHIT_W;
  localparam int KIND_W      = 2;
  localparam int SHORT_WORDS = 1;
  localparam int LONG_WORDS  = 8;

  typedef enum logic [KIND_W-1:0] {
    KIND_IDLE = 2'd0,
    KIND_TAG  = 2'd1,
    KIND_BODY = 2'd2,
    KIND_EOP  = 2'd3
  } flit_kind_e;
endpackage

// File: rtl/flit_tx_ser.sv
module flit_tx_ser
  import flit_link_pkg::*;
#(
  parameter int FW  = FLIT_W,
  parameter int PW  = PHIT_W,
  parameter int NPH = N_PHITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] flit_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic [PW-1:0] phit_o,
  output logic          phit_vld_o
);
  localparam int PAD_W = NPH * PW;
  localparam int PH_W  = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NPH - 1);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [PAD_W-1:0] shr_q, shr_d;
  logic [PW-1:0]    phit_q, phit_d;
  logic             vld_q;
  logic [PAD_W-1:0] padded;

  assign ready_o = (phase_q == '0);

  always_comb begin
    phase_d = (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
    padded  = '0;
    if (phase_q == '0) begin
      if (valid_i) padded = PAD_W'(flit_i);
      phit_d = padded[PW-1:0];
      shr_d  = padded >> PW;
    end else begin
      phit_d = shr_q[PW-1:0];
      shr_d  = shr_q >> PW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      shr_q   <= '0;
      phit_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      shr_q   <= shr_d;
      phit_q  <= phit_d;
      vld_q   <= 1'b1;
    end
  end

  assign phit_o     = phit_q;
  assign phit_vld_o = vld_q;

  // R3
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  // R2
  phit_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phit_vld_o |=> phit_vld_o);
endmodule

// File: rtl/link_pipe.sv
module link_pipe #(
  parameter int W      = 14,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic         v_i,
  output logic [W-1:0] d_o,
  output logic         v_o
);
  logic [W-1:0] d_st [STAGES+1];
  logic         v_st [STAGES+1];

  assign d_st[0] = d_i;
  assign v_st[0] = v_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_st[s+1] <= '0;
        v_st[s+1] <= 1'b0;
      end else begin
        d_st[s+1] <= d_st[s];
        v_st[s+1] <= v_st[s];
      end
    end
  end

  assign d_o = d_st[STAGES];
  assign v_o = v_st[STAGES];
endmodule

// File: rtl/flit_rx_deser.sv
module flit_rx_deser
  import flit_link_pkg::*;
#(
  parameter int FW  = FLIT_W,
  parameter int PW  = PHIT_W,
  parameter int NPH = N_PHITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phit_i,
  input  logic          phit_vld_i,
  output logic [FW-1:0] flit_o,
  output logic          flit_vld_o
);
  localparam int BUF_W = (NPH - 1) * PW;
  localparam int PH_W  = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NPH - 1);

  logic [PH_W-1:0]  cnt_q, cnt_d;
  logic [BUF_W-1:0] buf_q, buf_d;
  logic [FW-1:0]    flit_q, flit_d;
  logic             flit_en;
  logic             vld_q, vld_d;
  logic [BUF_W+PW-1:0] full;

  always_comb begin
    cnt_d   = cnt_q;
    buf_d   = buf_q;
    flit_en = 1'b0;
    vld_d   = 1'b0;
    full    = {phit_i, buf_q};
    flit_d  = full[FW-1:0];
    if (phit_vld_i) begin
      if (cnt_q == LAST_PH) begin
        cnt_d   = '0;
        flit_en = 1'b1;
        vld_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        buf_d = {phit_i, buf_q[BUF_W-1:PW]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flit_q <= '0;
    else if (flit_en) flit_q <= flit_d;
  end

  assign flit_o     = flit_q;
  assign flit_vld_o = vld_q;

  // R5
  flit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_vld_o |=> !flit_vld_o);
endmodule

// File: rtl/flit_framer.sv
module flit_framer
  import flit_link_pkg::*;
#(
  parameter int FW    = FLIT_W,
  parameter int DW    = FLIT_DATA_W,
  parameter int SHORT = SHORT_WORDS,
  parameter int LONG  = LONG_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] flit_i,
  input  logic          vld_i,
  output logic          deliver_o,
  output logic          eop_o,
  output logic          err_o
);
  localparam int CNT_W = $clog2(LONG + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  flit_kind_e       kind;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   total;

  assign kind  = flit_kind_e'(flit_i[DW +: KIND_W]);
  assign total = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    deliver_o = vld_i && (kind != KIND_IDLE);
    eop_o     = vld_i && (kind == KIND_EOP);
    err_o     = eop_o && (total != (CNT_W+1)'(SHORT)) && (total != (CNT_W+1)'(LONG));
    cnt_d     = cnt_q;
    if (vld_i) begin
      unique case (kind)
        KIND_TAG:  cnt_d = '0;
        KIND_BODY: cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        KIND_EOP:  cnt_d = '0;
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> (cnt_q == '0));
endmodule

// File: rtl/flit_phit_link.sv
module flit_phit_link
  import flit_link_pkg::*;
#(
  parameter int LINK_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLIT_W-1:0] tx_flit,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [PHIT_W-1:0] link_phit,
  output logic              link_phit_vld,
  output logic [FLIT_W-1:0] rx_flit,
  output logic              rx_flit_vld,
  output logic              rx_eop,
  output logic              rx_frame_err
);
  logic [PHIT_W-1:0] far_phit;
  logic              far_vld;
  logic [FLIT_W-1:0] raw_flit;
  logic              raw_vld;

  flit_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n), .flit_i(tx_flit), .valid_i(tx_valid),
    .ready_o(tx_ready), .phit_o(link_phit), .phit_vld_o(link_phit_vld)
  );

  link_pipe #(.W(PHIT_W), .STAGES(LINK_STAGES)) u_wire (
    .clk(clk), .rst_n(rst_n), .d_i(link_phit), .v_i(link_phit_vld),
    .d_o(far_phit), .v_o(far_vld)
  );

  flit_rx_deser u_rx (
    .clk(clk), .rst_n(rst_n), .phit_i(far_phit), .phit_vld_i(far_vld),
    .flit_o(raw_flit), .flit_vld_o(raw_vld)
  );

  flit_framer u_frm (
    .clk(clk), .rst_n(rst_n), .flit_i(raw_flit), .vld_i(raw_vld),
    .deliver_o(rx_flit_vld), .eop_o(rx_eop), .err_o(rx_frame_err)
  );

  assign rx_flit = raw_flit;

  // R7
  eop_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |-> rx_flit_vld);
endmodule

// File: tb/sim_flit_phit_link.sv
module sim_flit_phit_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [69:0] tx_flit = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [13:0] link_phit;
  logic        link_phit_vld;
  logic [69:0] rx_flit;
  logic        rx_flit_vld, rx_eop, rx_frame_err;

  int checks = 0;
  int fails  = 0;
  int model_cnt = 0;
  bit done = 1'b0;
  logic [71:0] expq[$];

  always #10 clk = ~clk;

  flit_phit_link u0 (
    .clk(clk), .rst_n(rst_n), .tx_flit(tx_flit), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .link_phit(link_phit), .link_phit_vld(link_phit_vld),
    .rx_flit(rx_flit), .rx_flit_vld(rx_flit_vld), .rx_eop(rx_eop),
    .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [69:0] mk(input logic [1:0] k, input logic [63:0] d, input logic [3:0] h);
    return {h, k, d};
  endfunction

  // expected model from R1, R6, R7, R8
  function automatic void push_exp(input logic [69:0] f);
    logic [1:0] k;
    logic err, eop;
    k = f[65:64];
    err = 1'b0;
    eop = 1'b0;
    case (k)
      2'd1: model_cnt = 0;
      2'd2: model_cnt++;
      2'd3: begin
        eop = 1'b1;
        err = ((model_cnt + 1) != 1) && ((model_cnt + 1) != 8);
        model_cnt = 0;
      end
      default: ;
    endcase
    if (k != 2'd0) expq.push_back({err, eop, f});
  endfunction

  task automatic send(input logic [69:0] f);
    while (!tx_ready) @(negedge clk);
    tx_flit  = f;
    tx_valid = 1'b1;
    push_exp(f);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // monitor: R5 R6 R7 R8
  always @(negedge clk) begin
    if (rst_n && rx_flit_vld) begin
      if (expq.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6 actual=%h expected=none", rx_flit);
      end else begin
        logic [71:0] e;
        e = expq.pop_front();
        chk("R5", {2'b00, rx_flit}, {2'b00, e[69:0]});
        chk("R7", {71'd0, rx_eop}, {71'd0, e[70]});
        chk("R8", {71'd0, rx_frame_err}, {71'd0, e[71]});
      end
    end else if (rst_n && (rx_eop || rx_frame_err)) begin
      checks++;
      fails++;
      $display("FAIL R7 actual=%b%b expected=00", rx_eop, rx_frame_err);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [69:0] f;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", {71'd0, link_phit_vld}, 72'd0);
    chk("R9", {71'd0, rx_flit_vld}, 72'd0);
    chk("R9", {70'd0, rx_eop, rx_frame_err}, 72'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 phit order and ready gap
    f = mk(2'd1, 64'hA5C3_0F1E_9B2D_7468, 4'hB);
    while (!tx_ready) @(negedge clk);
    tx_flit = f;
    tx_valid = 1'b1;
    push_exp(f);
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      tx_valid = 1'b0;
      chk("R2", {58'd0, link_phit}, {58'd0, f[14*i +: 14]});
      chk("R2", {71'd0, link_phit_vld}, 72'd1);
      chk("R3", {71'd0, tx_ready}, {71'd0, (i == 4)});
    end

    // 1-word packet, then 8-word packet, back to back (R5 R8)
    send(mk(2'd3, 64'h1111_0000_0000_0001, 4'h1));
    send(mk(2'd1, 64'h2222_0000_0000_0000, 4'h2));
    for (int i = 0; i < 7; i++) send(mk(2'd2, 64'h3000 + 64'(i), 4'(i)));
    send(mk(2'd3, 64'h3FFF, 4'h3));
    // 2-word packet: error
    send(mk(2'd1, 64'h4444, 4'h4));
    send(mk(2'd2, 64'h4001, 4'h5));
    send(mk(2'd3, 64'h4002, 4'h6));
    // 9-word packet: error
    send(mk(2'd1, 64'h5555, 4'h7));
    for (int i = 0; i < 8; i++) send(mk(2'd2, 64'h5000 + 64'(i), 4'h8));
    send(mk(2'd3, 64'h5FFF, 4'h9));
    // R6 offered idle flit with payload, dropped
    send(mk(2'd0, 64'hDEAD_BEEF_DEAD_BEEF, 4'hF));
    // tag cuts a packet short, then 1-word: no error (R8)
    send(mk(2'd1, 64'h6666, 4'hA));
    for (int i = 0; i < 3; i++) send(mk(2'd2, 64'h6000 + 64'(i), 4'hA));
    send(mk(2'd1, 64'h6677, 4'hC));
    repeat (13) @(negedge clk);
    send(mk(2'd3, 64'h6FFF, 4'hD));

    // drain and check idle fill (R4)
    repeat (40) @(negedge clk);
    chk("R5", {64'd0, 8'(expq.size())}, 72'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R4", {58'd0, link_phit}, 72'd0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule